// File: doc/BRIEF.md
# RTC Index/Data Register Interface

This block is the host-facing register front end of a real-time clock. The host sees two byte addresses. The even address selects one of 128 register indices. The odd address reads or writes the register at that index. Four of the indices are the clock's control and status registers:

| Name | Index | Role |
|------|-------|------|
| A | 0x0A | rate and divider control |
| B | 0x0B | mode and interrupt enables |
| C | 0x0C | interrupt flags |
| D | 0x0D | constant status |

All other indices are plain byte storage.

The time counting itself lives elsewhere. Timing blocks send one-cycle event pulses for the periodic, alarm and update-ended sources. They also send a level that marks the short window before each one-second update. This block latches the events as flags and combines them with the enables into one interrupt line. In return it hands the timing blocks:
- the rate and divider fields;
- the register B image;
- a run indication;
- a pulse when the dividers leave their held state. The timing block uses this pulse to place the first update half a second later.

Reads return data one clock after the read strobe. Reading register C hands back every pending flag and clears them in the same access.

Top module: `rtc_index_port`

## Requirements
- R1: A write to address 0 stores host_wdata[6:0] as the index, and bit 7 is dropped. A read of address 0 returns 0xFF on host_rdata one cycle after the strobe.
- R2: A byte written through address 1 at any index other than 0x0A–0x0D reads back unchanged through address 1 one cycle after the read strobe.
- R3: Writes to index 0x0C (C) and 0x0D (D) change nothing. D always reads 0x80.
- R4: Bit 7 of A cannot be written. On a read of A, bit 7 equals uip_window only while the clock runs, and is 0 otherwise. The clock runs when B bit 7 is 0 and A bits 6:4 are ≤ 2.
- R5: Each event pulse sets its flag in C: evt_periodic sets bit 6, evt_alarm sets bit 5, evt_update sets bit 4. If the matching enable in B is 1, C bit 7 and irq_out become 1 in the next cycle. The enables are B bit 6 (periodic), bit 5 (alarm) and bit 4 (update).
- R6: A read of C returns its value, then C becomes 0x00 and irq_out drops. An event arriving in the same cycle as the read is kept as a flag and can re-raise the line.
- R7: When B is written, C bit 7 and irq_out become 1 if any new enable matches a pending flag. Otherwise both become 0, and the flags stay untouched.
- R8: A write to B with bit 7 (set mode) at 1 stores bit 4 (update enable) as 0.
- R9: While A bits 6:5 are both 1 (dividers held), evt_alarm and evt_update set no flag. evt_periodic still does.
- R10: A write to A that moves it out of the held state, with new bits 6:4 ≤ 2 and B bit 7 at 0, gives a one-cycle div_restart pulse. Any other write to A gives no pulse.
- R11: After reset, A = 0x26, B = 0x02, C = 0x00 and D = 0x80, irq_out is 0, and the periodic, alarm and square-wave enables are off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| host_wr | input | 1 | host write strobe |
| host_rd | input | 1 | host read strobe |
| host_addr | input | 1 | 0 = index port, 1 = data port |
| host_wdata | input | 8 | host write byte |
| host_rdata | output | 8 | read byte, valid the cycle after host_rd |
| evt_periodic | input | 1 | periodic event pulse |
| evt_alarm | input | 1 | alarm match pulse |
| evt_update | input | 1 | update-ended pulse |
| uip_window | input | 1 | high during the last 8 ticks of the 32.768 kHz clock before an update |
| irq_out | output | 1 | interrupt line, equals C bit 7 |
| rate_sel | output | 4 | A bits 3:0, periodic rate code |
| div_sel | output | 3 | A bits 6:4, divider field |
| clock_run | output | 1 | set mode off and divider field ≤ 2 |
| div_restart | output | 1 | one-cycle pulse on leaving divider hold |
| mode_b | output | 8 | image of register B |

## Verification
The hardest case is an event pulse that lands in the very cycle the host reads C. Here the clear and the new flag compete for the same flop. The bench drives the read strobe and evt_update on the same falling edge, with the update enable set. It then expects the old flags in the returned byte, irq_out still high afterwards, and a second read of C that shows the surviving flag. The divider-release pulse is just as narrow. It is reached by writing A into the held state, and then out of it under three conditions: a valid field, an invalid field, and set mode on.

// File: rtl/rtc_if_pkg.sv
package rtc_if_pkg;
  localparam int DATA_W = 8;

  localparam int IDX_A = 'h0A;
  localparam int IDX_B = 'h0B;
  localparam int IDX_C = 'h0C;
  localparam int IDX_D = 'h0D;

  localparam int B_SET = 7;
  localparam int B_UIE = 4;
  localparam int C_SUM = 7;
  localparam int C_PF  = 6;
  localparam int C_AF  = 5;
  localparam int C_UF  = 4;

  localparam logic [DATA_W-1:0] A_RST  = 8'h26;
  localparam logic [DATA_W-1:0] B_RST  = 8'h02;
  localparam logic [DATA_W-1:0] D_CONST = 8'h80;
  localparam logic [DATA_W-1:0] EVEN_RD = 8'hFF;

  typedef enum logic [1:0] {SRC_CTL, SRC_RAM} rd_src_e;
endpackage

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/rtc_ctl_regs.sv
module rtc_ctl_regs import rtc_if_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic [DATA_W-1:0] wdata,
  input  logic              uip_window,
  output logic [6:0]        a_q,
  output logic [DATA_W-1:0] b_q,
  output logic [DATA_W-1:0] b_next,
  output logic [DATA_W-1:0] a_read,
  output logic              div_hold,
  output logic              clock_run,
  output logic              div_restart
);
  logic leaving_hold;

  always_comb begin
    b_next = wdata;
    if (wdata[B_SET]) b_next[B_UIE] = 1'b0;
  end

  assign div_hold     = (a_q[6:5] == 2'b11);
  assign clock_run    = !b_q[B_SET] && (a_q[6:4] <= 3'd2);
  assign a_read       = {uip_window & clock_run, a_q};
  assign leaving_hold = div_hold && (wdata[6:4] <= 3'd2) && !b_q[B_SET];

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q         <= A_RST[6:0];
      b_q         <= B_RST;
      div_restart <= 1'b0;
    end else begin
      div_restart <= wr_a && leaving_hold;
      if (wr_a) a_q <= wdata[6:0];
      if (wr_b) b_q <= b_next;
    end
  end

  // R8: set mode never coexists with the update enable
  p_set_masks_uie_r8: assert property (@(posedge clk) disable iff (rst)
    b_q[B_SET] |-> !b_q[B_UIE]);

  // R10: restart is a single-cycle pulse
  p_restart_single_r10: assert property (@(posedge clk) disable iff (rst)
    div_restart |=> !div_restart);

  // R10: restart only follows a held divider
  p_restart_needs_hold_r10: assert property (@(posedge clk) disable iff (rst)
    div_restart |-> $past(div_hold));
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit import rtc_if_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_periodic,
  input  logic              evt_alarm,
  input  logic              evt_update,
  input  logic              updates_live,
  input  logic [2:0]        en_now,
  input  logic              b_wr,
  input  logic [2:0]        en_new,
  input  logic              rd_clear,
  output logic [DATA_W-1:0] c_q,
  output logic              irq_out
);
  logic [2:0] new_flags;
  logic [2:0] kept;
  logic [2:0] flags_next;
  logic       sum_next;

  assign new_flags  = {evt_periodic, evt_alarm & updates_live, evt_update & updates_live};
  assign kept       = rd_clear ? 3'b000 : c_q[C_PF:C_UF];
  assign flags_next = kept | new_flags;

  always_comb begin
    if (b_wr)          sum_next = |(en_new & flags_next);
    else if (rd_clear) sum_next = |(en_now & new_flags);
    else               sum_next = c_q[C_SUM] | (|(en_now & new_flags));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q     <= '0;
      irq_out <= 1'b0;
    end else begin
      c_q     <= {sum_next, flags_next, 4'b0000};
      irq_out <= sum_next;
    end
  end

  // R5: the periodic flag only rises after a periodic pulse
  p_pf_needs_event_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(c_q[C_PF]) |-> $past(evt_periodic));

  // R6: a quiet read of C empties it and drops the line
  p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_clear && !evt_periodic && !evt_alarm && !evt_update) |=> (c_q == 8'h00 && !irq_out));

  // R9: held dividers keep the update flag from rising
  p_hold_blocks_update_r9: assert property (@(posedge clk) disable iff (rst)
    (!updates_live && !c_q[C_UF]) |=> !c_q[C_UF]);

  // R7: the line rises only on a B write or an enabled event
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(b_wr || (|(en_now & {evt_periodic, evt_alarm, evt_update}))));
endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port import rtc_if_pkg::*; #(
  parameter int IDX_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              evt_periodic,
  input  logic              evt_alarm,
  input  logic              evt_update,
  input  logic              uip_window,
  output logic              irq_out,
  output logic [3:0]        rate_sel,
  output logic [2:0]        div_sel,
  output logic              clock_run,
  output logic              div_restart,
  output logic [DATA_W-1:0] mode_b
);
  logic [IDX_W-1:0]  idx_q;
  logic              wr_data, rd_data;
  logic              hit_a, hit_b, hit_c, hit_d, hit_ctl;
  logic [6:0]        a_q;
  logic [DATA_W-1:0] b_q, b_next, a_read, c_q, ram_q, ctl_q;
  logic              div_hold;
  rd_src_e           src_q;

  assign wr_data = host_wr && host_addr;
  assign rd_data = host_rd && host_addr;
  assign hit_a   = (idx_q == IDX_W'(IDX_A));
  assign hit_b   = (idx_q == IDX_W'(IDX_B));
  assign hit_c   = (idx_q == IDX_W'(IDX_C));
  assign hit_d   = (idx_q == IDX_W'(IDX_D));
  assign hit_ctl = hit_a || hit_b || hit_c || hit_d;

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (host_wr && !host_addr) idx_q <= host_wdata[IDX_W-1:0];
  end

  rtc_byte_store #(.ADDR_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (wr_data && !hit_ctl),
    .waddr (idx_q),
    .wdata (host_wdata),
    .re    (rd_data),
    .raddr (idx_q),
    .q     (ram_q)
  );

  rtc_ctl_regs u_ctl (
    .clk         (clk),
    .rst         (rst),
    .wr_a        (wr_data && hit_a),
    .wr_b        (wr_data && hit_b),
    .wdata       (host_wdata),
    .uip_window  (uip_window),
    .a_q         (a_q),
    .b_q         (b_q),
    .b_next      (b_next),
    .a_read      (a_read),
    .div_hold    (div_hold),
    .clock_run   (clock_run),
    .div_restart (div_restart)
  );

  rtc_flag_unit u_flags (
    .clk          (clk),
    .rst          (rst),
    .evt_periodic (evt_periodic),
    .evt_alarm    (evt_alarm),
    .evt_update   (evt_update),
    .updates_live (!div_hold),
    .en_now       (b_q[6:4]),
    .b_wr         (wr_data && hit_b),
    .en_new       (b_next[6:4]),
    .rd_clear     (rd_data && hit_c),
    .c_q          (c_q),
    .irq_out      (irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      src_q <= SRC_CTL;
    end else if (host_rd) begin
      src_q <= (host_addr && !hit_ctl) ? SRC_RAM : SRC_CTL;
      if (!host_addr)  ctl_q <= EVEN_RD;
      else if (hit_a)  ctl_q <= a_read;
      else if (hit_b)  ctl_q <= b_q;
      else if (hit_c)  ctl_q <= c_q;
      else if (hit_d)  ctl_q <= D_CONST;
      else             ctl_q <= '0;
    end
  end

  assign host_rdata = (src_q == SRC_RAM) ? ram_q : ctl_q;
  assign rate_sel   = a_q[3:0];
  assign div_sel    = a_q[6:4];
  assign mode_b     = b_q;

  // R1: even-address reads return all ones
  p_even_read_ff_r1: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_addr) |=> (host_rdata == EVEN_RD));

  // R3: register D reads as its constant
  p_d_constant_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_data && hit_d) |=> (host_rdata == D_CONST));
endmodule

// File: tb/test_rtc_index_port.sv
module test_rtc_index_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       evt_periodic = 1'b0, evt_alarm = 1'b0, evt_update = 1'b0;
  logic       uip_window = 1'b0;
  logic       irq_out, clock_run, div_restart;
  logic [3:0] rate_sel;
  logic [2:0] div_sel;
  logic [7:0] mode_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  rtc_index_port i_rtc_index_port (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
    .uip_window(uip_window), .irq_out(irq_out), .rate_sel(rate_sel),
    .div_sel(div_sel), .clock_run(clock_run), .div_restart(div_restart),
    .mode_b(mode_b)
  );

  // entry: {op[1:0] (0 write, 1 read+check), addr, data, expected, req}
  localparam int NV = 34;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0,1'b0,8'h0A,8'h00,4'd11}, {2'd1,1'b1,8'h00,8'h26,4'd11}, // R11 A
    {2'd0,1'b0,8'h0B,8'h00,4'd11}, {2'd1,1'b1,8'h00,8'h02,4'd11}, // R11 B
    {2'd0,1'b0,8'h0C,8'h00,4'd11}, {2'd1,1'b1,8'h00,8'h00,4'd11}, // R11 C
    {2'd0,1'b0,8'h0D,8'h00,4'd11}, {2'd1,1'b1,8'h00,8'h80,4'd11}, // R11 D
    {2'd0,1'b1,8'h55,8'h00,4'd3},  {2'd1,1'b1,8'h00,8'h80,4'd3},  // R3 D write
    {2'd0,1'b0,8'h0C,8'h00,4'd3},  {2'd0,1'b1,8'hF0,8'h00,4'd3},  // R3 C write
    {2'd1,1'b1,8'h00,8'h00,4'd3},
    {2'd1,1'b0,8'h00,8'hFF,4'd1},                                 // R1 even read
    {2'd0,1'b0,8'h8E,8'h00,4'd1},  {2'd0,1'b1,8'h3C,8'h00,4'd1},  // R1 index bit 7 dropped
    {2'd0,1'b0,8'h0E,8'h00,4'd1},  {2'd1,1'b1,8'h00,8'h3C,4'd1},
    {2'd0,1'b0,8'h7F,8'h00,4'd2},  {2'd0,1'b1,8'hA5,8'h00,4'd2},  // R2 storage
    {2'd0,1'b0,8'h00,8'h00,4'd2},  {2'd0,1'b1,8'h11,8'h00,4'd2},
    {2'd0,1'b0,8'h7F,8'h00,4'd2},  {2'd1,1'b1,8'h00,8'hA5,4'd2},
    {2'd0,1'b0,8'h00,8'h00,4'd2},  {2'd1,1'b1,8'h00,8'h11,4'd2},
    {2'd0,1'b0,8'h0A,8'h00,4'd4},  {2'd0,1'b1,8'hA3,8'h00,4'd4},  // R4 UIP not writable
    {2'd1,1'b1,8'h00,8'h23,4'd4},
    {2'd0,1'b0,8'h0B,8'h00,4'd8},  {2'd0,1'b1,8'h92,8'h00,4'd8},  // R8 set mode drops UIE
    {2'd1,1'b1,8'h00,8'h82,4'd8},
    {2'd0,1'b1,8'h02,8'h00,4'd8},  {2'd1,1'b1,8'h00,8'h02,4'd8}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    rv = host_rdata;
  endtask

  task automatic pulse(input logic p, input logic al, input logic u);
    @(negedge clk);
    evt_periodic = p; evt_alarm = al; evt_update = u;
    @(negedge clk);
    evt_periodic = 1'b0; evt_alarm = 1'b0; evt_update = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    wr(1'b0, idx);
    wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx);
    wr(1'b0, idx);
    rd(1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state at the ports
    check("R11 irq", {7'b0, irq_out}, 8'h00);
    check("R11 mode_b", mode_b, 8'h02);
    check("R11 rate/div", {1'b0, div_sel, rate_sel}, 8'h26);
    check("R11 restart", {7'b0, div_restart}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][22:21] == 2'd0) wr(VEC[i][20], VEC[i][19:12]);
      else begin
        rd(VEC[i][20]);
        checks++;
        if (rv !== VEC[i][11:4]) begin
          fails++;
          $display("FAIL R%0d vector %0d actual=%02h expected=%02h", VEC[i][3:0], i, rv, VEC[i][11:4]);
        end
      end
    end

    // R4: UIP follows the window only while the clock runs
    reg_wr(8'h0A, 8'h26);
    uip_window = 1'b1;
    reg_rd(8'h0A); check("R4 uip running", rv, 8'hA6);
    reg_wr(8'h0B, 8'h82);
    reg_rd(8'h0A); check("R4 uip set mode", rv, 8'h26);
    reg_wr(8'h0B, 8'h02);
    reg_wr(8'h0A, 8'h66);
    reg_rd(8'h0A); check("R4 uip held", rv, 8'h66);
    uip_window = 1'b0;

    // R10: release from hold
    reg_wr(8'h0A, 8'h26);
    check("R10 restart pulse", {7'b0, div_restart}, 8'h01);
    @(negedge clk);
    check("R10 pulse ends", {7'b0, div_restart}, 8'h00);
    reg_wr(8'h0A, 8'h66);
    reg_wr(8'h0A, 8'h46);
    check("R10 bad field no pulse", {7'b0, div_restart}, 8'h00);
    reg_wr(8'h0A, 8'h66);
    reg_wr(8'h0B, 8'h82);
    reg_wr(8'h0A, 8'h26);
    check("R10 set mode no pulse", {7'b0, div_restart}, 8'h00);
    reg_wr(8'h0B, 8'h02);

    // R5 / R6: periodic with enable, read clears
    reg_wr(8'h0B, 8'h42);
    reg_rd(8'h0C); // empty any flag
    pulse(1'b1, 1'b0, 1'b0);
    check("R5 periodic irq", {7'b0, irq_out}, 8'h01);
    rd(1'b1); check("R6 read C value", rv, 8'hC0);
    check("R6 irq dropped", {7'b0, irq_out}, 8'h00);
    rd(1'b1); check("R6 C cleared", rv, 8'h00);

    // R5: flag without enable
    reg_wr(8'h0B, 8'h02);
    pulse(1'b0, 1'b0, 1'b1);
    check("R5 no enable no irq", {7'b0, irq_out}, 8'h00);
    reg_rd(8'h0C); check("R5 update flag", rv, 8'h10);

    // R7: enabling a pending flag raises the line; disabling lowers it
    pulse(1'b0, 1'b1, 1'b0);
    check("R7 pending no irq", {7'b0, irq_out}, 8'h00);
    reg_wr(8'h0B, 8'h22);
    check("R7 enable raises", {7'b0, irq_out}, 8'h01);
    reg_wr(8'h0B, 8'h02);
    check("R7 disable lowers", {7'b0, irq_out}, 8'h00);
    reg_rd(8'h0C); check("R7 flag kept summary clear", rv, 8'h20);

    // R9: held dividers suppress alarm and update flags
    reg_wr(8'h0A, 8'h66);
    pulse(1'b0, 1'b1, 1'b1);
    reg_rd(8'h0C); check("R9 held no flags", rv, 8'h00);
    pulse(1'b1, 1'b0, 1'b0);
    rd(1'b1); check("R9 periodic still", rv, 8'h40);
    reg_wr(8'h0A, 8'h26);

    // R6: event in the same cycle as the read of C survives
    reg_wr(8'h0B, 8'h12);
    wr(1'b0, 8'h0C);
    pulse(1'b0, 1'b0, 1'b1);
    check("R5 update irq", {7'b0, irq_out}, 8'h01);
    @(negedge clk);
    host_rd = 1'b1; host_addr = 1'b1; evt_update = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; evt_update = 1'b0; rv = host_rdata;
    check("R6 same-cycle read value", rv, 8'h90);
    check("R6 same-cycle irq kept", {7'b0, irq_out}, 8'h01);
    rd(1'b1); check("R6 surviving flag", rv, 8'h90);

    // R11: reset in mid-run
    reg_wr(8'h0B, 8'h6A);
    pulse(1'b1, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check("R11 irq after reset", {7'b0, irq_out}, 8'h00);
    reg_rd(8'h0B); check("R11 B after reset", rv, 8'h02);
    reg_rd(8'h0A); check("R11 A after reset", rv, 8'h26);
    reg_rd(8'h0C); check("R11 C after reset", rv, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule